// File: doc/BRIEF.md
# Alternating-Half Toggle PWM DAC

This block is a pulse-width audio DAC built from a free-running counter that only counts up and an output that flips state whenever the counter meets a compare register. Consecutive counter periods are grouped into pairs. In the first (odd) period of a pair, the compare value is mirrored against the counter's top value, so the output rises late in that period. In the second (even) period, the compare value is used as it stands, so the output falls early in that period. The result is one high pulse centred on the boundary between the two periods, which is how a centre-aligned PWM behaves, even though the timer never counts down.

Each sample has one bit more than the counter. The upper bits are the integer level and the lowest bit is a half-step. The odd period rounds the sample down and the even period rounds it up, so the half-step adds exactly one count of high time per pair. A synthesis engine upstream presents samples with a valid strobe at any time. The block keeps the most recent one and takes it at the start of the next pair, so the sample rate is half the counter wrap rate. An analog low-pass filter after the output turns the pulse stream into audio.

Top module: `toggle_pwm_dac`

## Requirements
- R1: The counter runs 0 to 2^CNT_W-1 (255 by default) and wraps, so each period is 256 clocks and a pair is 512 clocks. Pair position 0 is the first cycle after reset is released; positions 0..255 are the odd period and 256..511 the even period.
- R2: The output is low while reset is held, and it is low in the first cycle of every pair.
- R3: The output changes state only in the cycle after the counter equals the compare value. It flips at that point and is never forced to a fixed level, so each pair shows exactly one contiguous high run.
- R4: Let the sample be s, with N = s[8:1] (rounded down). In the odd period the compare value is 255-N, so the first high cycle of the pair is at position 256-N.
- R5: In the even period the compare value is M = N + s[0] (rounded up), saturated at 255. The last high cycle of the pair is at position 256+M.
- R6: A sample is taken only at the wrap from an even period into an odd period. A strobe presented in the final cycle of a pair (position 511) is included. Strobes arriving anywhere in a pair affect only the next pair, and when several arrive, the last one wins. The data lines are ignored while the strobe is low.
- R7: If a pair receives no strobe, the next pair reuses the sample in effect.
- R8: The high time over a pair is N+M+1 clocks. This is the sample in half-steps plus one, or equal to it when R5 saturates.
- R9: A sample of 0 gives compare values 255 and 0. The result is a single one-clock pulse at position 256, which is the first cycle of the even period. This is also the output of the first pair after reset, before any strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_data | input | CNT_W+1 | Sample: integer level in the upper CNT_W bits, half-step in bit 0 |
| smp_valid | input | 1 | Strobe marking smp_data as a new sample |
| pwm_out | output | 1 | PWM output bit |

## Verification
For every pair, the bench records the first high position, the last high position and the total high count. These are compared against values derived from the rounding rules. Mismatches in the rise position, the fall position and the total separate errors in the round-down path, the round-up path and the toggle behaviour. Directed samples cover 0, a lone half-step, the top levels where round-up saturates, and odd and even neighbours. In addition, some pairs get a junk strobe overridden by a later one, a strobe in the final cycle of a pair, or no strobe at all, which exposes sample timing and hold errors. Random samples and strobe positions, with noise on the data lines while the strobe is low, then check that only strobed values matter.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
   typedef enum logic {
      PH_ODD  = 1'b0,
      PH_EVEN = 1'b1
   } phase_e;
endpackage

// File: rtl/tpwm_counter.sv
module tpwm_counter
   import tpwm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap,
   output phase_e           phase
);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic [CNT_W-1:0] cnt_q;
   phase_e           phase_q;

   assign wrap = (cnt_q == TOP);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         phase_q <= PH_ODD;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (wrap) begin
            phase_q <= (phase_q == PH_ODD) ? PH_EVEN : PH_ODD;
         end
      end
   end

   assign cnt   = cnt_q;
   assign phase = phase_q;

   // R1: count steps by one and returns to zero after the top value
   p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (cnt_q == '0));
   p_step_r1: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> (cnt_q == $past(cnt_q) + 1'b1));
   p_phase_r1: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> $stable(phase_q));
endmodule

// File: rtl/tpwm_compare.sv
module tpwm_compare
   import tpwm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wrap,
   input  phase_e           phase,
   input  logic [CNT_W:0]   smp_data,
   input  logic             smp_valid,
   output logic [CNT_W-1:0] cmp
);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic [CNT_W:0]   pend_q;
   logic [CNT_W:0]   act_q;
   logic [CNT_W:0]   take;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W:0]   up_sum;
   logic [CNT_W-1:0] up_sat;
   logic             enter_odd;
   logic             enter_even;

   assign enter_odd  = wrap && (phase == PH_EVEN);
   assign enter_even = wrap && (phase == PH_ODD);
   assign take       = smp_valid ? smp_data : pend_q;

   // round up the held sample and clip at the top count
   assign up_sum = {1'b0, act_q[CNT_W:1]} + {{CNT_W{1'b0}}, act_q[0]};
   assign up_sat = up_sum[CNT_W] ? TOP : up_sum[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= '0;
         act_q  <= '0;
         cmp_q  <= TOP;
      end else begin
         if (smp_valid) begin
            pend_q <= smp_data;
         end
         if (enter_odd) begin
            act_q <= take;
            cmp_q <= TOP - take[CNT_W:1];
         end else if (enter_even) begin
            cmp_q <= up_sat;
         end
      end
   end

   assign cmp = cmp_q;

   // R6: held sample changes only when an odd period begins
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !enter_odd |=> $stable(act_q));
   // R4: mirrored, rounded-down compare value in the odd period
   p_odd_cmp_r4: assert property (@(posedge clk) disable iff (rst)
      enter_odd |=> (cmp_q == TOP - act_q[CNT_W:1]));
   // R5: rounded-up compare value, saturated, in the even period
   p_even_cmp_r5: assert property (@(posedge clk) disable iff (rst)
      enter_even |=> (act_q[0] == 1'b0) ? (cmp_q == act_q[CNT_W:1])
                     : ((act_q[CNT_W:1] == TOP) ? (cmp_q == TOP)
                        : (cmp_q == act_q[CNT_W:1] + 1'b1)));
   p_cmp_stable_r5: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> $stable(cmp_q));
endmodule

// File: rtl/tpwm_toggle.sv
module tpwm_toggle #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   output logic             pwm
);
   logic pwm_q;
   logic hit;

   assign hit = (cnt == cmp);

   always_ff @(posedge clk) begin
      if (rst) begin
         pwm_q <= 1'b0;
      end else if (hit) begin
         pwm_q <= ~pwm_q;
      end
   end

   assign pwm = pwm_q;
endmodule

// File: rtl/toggle_pwm_dac.sv
module toggle_pwm_dac
   import tpwm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [CNT_W:0] smp_data,
   input  logic           smp_valid,
   output logic           pwm_out
);
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("toggle_pwm_dac: CNT_W must lie in 2..16");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cmp;
   logic             wrap;
   phase_e           phase;

   tpwm_counter #(.CNT_W(CNT_W)) u_counter (
      .clk   (clk),
      .rst   (rst),
      .cnt   (cnt),
      .wrap  (wrap),
      .phase (phase)
   );

   tpwm_compare #(.CNT_W(CNT_W)) u_compare (
      .clk       (clk),
      .rst       (rst),
      .wrap      (wrap),
      .phase     (phase),
      .smp_data  (smp_data),
      .smp_valid (smp_valid),
      .cmp       (cmp)
   );

   tpwm_toggle #(.CNT_W(CNT_W)) u_toggle (
      .clk (clk),
      .rst (rst),
      .cnt (cnt),
      .cmp (cmp),
      .pwm (pwm_out)
   );

   // R2: every pair opens with the output low
   p_low_at_pair_start_r2: assert property (@(posedge clk) disable iff (rst)
      (cnt == '0 && phase == PH_ODD) |-> !pwm_out);
   // R3: output flips exactly after a compare hit and holds otherwise
   p_toggle_on_hit_r3: assert property (@(posedge clk) disable iff (rst)
      (cnt == cmp) |=> (pwm_out != $past(pwm_out)));
   p_hold_no_hit_r3: assert property (@(posedge clk) disable iff (rst)
      (cnt != cmp) |=> (pwm_out == $past(pwm_out)));
endmodule

// File: tb/toggle_pwm_dac_tb.sv
module toggle_pwm_dac_tb;
   localparam int W      = 8;
   localparam int PERIOD = 256;
   localparam int PAIR   = 512;
   localparam int NPAIRS = 30;
   localparam int NDIR   = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W:0]   smp_data = '0;
   logic         smp_valid = 1'b0;
   logic         pwm_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   toggle_pwm_dac #(.CNT_W(W)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .smp_data  (smp_data),
      .smp_valid (smp_valid),
      .pwm_out   (pwm_out)
   );

   function automatic int exp_first(int s);
      return PERIOD - (s >> 1);
   endfunction

   function automatic int exp_last(int s);
      int m;
      m = (s >> 1) + (s & 1);
      if (m > PERIOD - 1) m = PERIOD - 1;
      return PERIOD + m;
   endfunction

   function automatic int exp_high(int s);
      return exp_last(s) - exp_first(s) + 1;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finished run");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int dirv [NDIR] = '{1, 2, 0, 255, 256, 510, 511, 3, 128, 509};
      int cur;
      int nxt;
      string tag;
      process::self().srandom(32'h5eed_0042);
      void'($urandom(32'h1234_abcd));

      repeat (3) @(negedge clk);
      chk("R2", "output during reset", int'(pwm_out), 0);
      rst = 1'b0;
      cur = 0;
      tag = "R9";

      for (int p = 0; p < NPAIRS; p++) begin
         int ia;
         int ib;
         int hi;
         int first;
         int last;
         int low0;
         string ntag;
         ia = -1;
         ib = -1;
         if (p < NDIR) begin
            nxt = dirv[p];
            ib = (p == 3) ? PAIR - 1 : 100 + p * 7;
            if (p % 3 == 0) ia = 40 + p;
            ntag = (p == 3) ? "R6 last-cycle strobe" : ((ia >= 0) ? "R6 last strobe wins" : "R6");
         end else if (p == NDIR) begin
            nxt = cur;
            ntag = "R7 no strobe";
         end else begin
            nxt = int'($urandom % PAIR);
            ib = int'($urandom % PAIR);
            if (ib > 0 && ($urandom % 2) == 1) ia = int'($urandom % ib);
            ntag = "R6 random";
         end

         hi = 0;
         first = -1;
         last = -1;
         low0 = int'(pwm_out);
         for (int i = 0; i < PAIR; i++) begin
            if (pwm_out) begin
               hi++;
               if (first < 0) first = i;
               last = i;
            end
            smp_valid = (i == ia) || (i == ib);
            smp_data  = (i == ib) ? nxt[W:0] : (W+1)'($urandom);
            @(negedge clk);
         end
         smp_valid = 1'b0;

         chk("R2", $sformatf("pair %0d start level", p), low0, 0);
         chk("R8", $sformatf("pair %0d high time s=%0d (%s)", p, cur, tag), hi, exp_high(cur));
         chk("R4", $sformatf("pair %0d rise position s=%0d", p, cur), first, exp_first(cur));
         chk("R5 R1", $sformatf("pair %0d fall position s=%0d", p, cur), last, exp_last(cur));
         chk("R3", $sformatf("pair %0d single contiguous run", p), hi, last - first + 1);
         if (cur == 0) begin
            chk("R9", $sformatf("pair %0d zero pulse width", p), hi, 1);
            chk("R9", $sformatf("pair %0d zero pulse position", p), first, PERIOD);
         end
         cur = nxt;
         tag = ntag;
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule